// File: doc/BRIEF.md
# Pin-Change Interrupt Unit

This unit watches a 32-bit bank of general-purpose input pins and raises one level-sensitive interrupt request when a watched pin changes level. Each pin has a sticky change flag and a mask bit. Software sets mask bits through one write address and clears them through another. It can read the mask back. It collects and clears all pending flags with one read of the status address.

A pin is watched only while it is under general-purpose control (`pio_sel_i` high) and its output driver is off (`oe_i` low). For each watched pin the unit keeps a sampled reference level. A flag is raised when the pin differs from that reference. While a pin is not watched, its reference stays frozen. A level that differs on its return to watched mode is therefore reported as a change. The pin inputs are taken as already synchronous to `clk_i`.

Register access is a single-cycle request. Writes take effect at the clock edge that samples them. Read data appears on `rdata_o` in the cycle after the request and is zero in every other cycle.

Top module: `pcint_unit`

## Requirements
- R1: While reset is asserted and right after it, the mask and all change flags are zero, `irq_o` is low, `rdata_o` is zero, and the sampled reference of every pin is 0.
- R2: At a clock edge where a watched pin differs from its sampled reference, that pin's flag becomes 1 and the reference takes the pin level. Both rising and falling changes count. A pin that holds its level sets no flag.
- R3: A pin whose `oe_i` bit is 1 sets no flag, whatever its level does.
- R4: A pin whose `pio_sel_i` bit is 0 (peripheral control) sets no flag, whatever its level does.
- R5: `irq_o` is 1 exactly when some bit is set in both the flags and the mask. It follows the registered state with no added cycle.
- R6: A write to address 0x40 sets the mask bits where `wdata_i` is 1. A write to 0x44 clears them. A read of 0x48 returns the mask on `rdata_o` one cycle later.
- R7: A read of 0x4C returns all flags on `rdata_o` one cycle later and clears every flag at the same edge, so `irq_o` drops.
- R8: A change detected at the same edge as a status read is not included in that read's data. It is kept as a set flag for the next read.
- R9: Clearing or setting mask bits never alters the flags. Re-enabling a mask bit over a pending flag raises `irq_o` again.
- R10: Reads of any other address return zero. Writes to 0x48, 0x4C or any unmapped address change nothing.
- R11: While a pin is not watched, its reference is frozen. If the pin returns to watched mode at a different level, a flag is set at the first edge after it returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 32 | Pin levels, synchronous to clk_i |
| pio_sel_i | input | 32 | 1 = pin under general-purpose control |
| oe_i | input | 32 | 1 = pin output driver enabled |
| req_i | input | 1 | Register access request, one cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Register byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read request |
| irq_o | output | 1 | Interrupt request, level |

## Verification
A pin change presented before an edge is seen as a flag at that edge. `irq_o` changes right after that same edge, and so does a mask update. Read data is due one edge after the request. The bench drives every input just after a rising edge. It updates a bit-level model of the flags, mask and references for that coming edge, and compares `irq_o` and `rdata_o` one nanosecond after the edge. A single-pin sweep crosses every pin with all four combinations of the select and output-enable bits. Arithmetic multi-pin patterns with interleaved mask writes and status reads follow, and the bench then targets a read that coincides with a change.

// File: rtl/pcint_pkg.sv
package pcint_pkg;
  localparam int unsigned ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFF_MASK_SET = 8'h40;
  localparam logic [ADDR_W-1:0] OFF_MASK_CLR = 8'h44;
  localparam logic [ADDR_W-1:0] OFF_MASK_RD  = 8'h48;
  localparam logic [ADDR_W-1:0] OFF_STATUS   = 8'h4C;

  typedef struct packed {
    logic mask_set;
    logic mask_clr;
    logic mask_rd;
    logic stat_rd;
  } pcint_dec_t;
endpackage

// File: rtl/pcint_detect.sv
module pcint_detect #(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] pin_i,
  input  logic [NPINS-1:0] pio_sel_i,
  input  logic [NPINS-1:0] oe_i,
  output logic [NPINS-1:0] chg_o,
  output logic [NPINS-1:0] smp_o
);
  logic [NPINS-1:0] smp_q;

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    logic watch;
    assign watch    = pio_sel_i[g] & ~oe_i[g];
    assign chg_o[g] = watch & (pin_i[g] ^ smp_q[g]);

    // reference frozen while the pin is not watched
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    smp_q[g] <= 1'b0;
      else if (watch) smp_q[g] <= pin_i[g];
    end
  end

  assign smp_o = smp_q;
endmodule

// File: rtl/pcint_flags.sv
module pcint_flags #(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] chg_i,
  input  logic             clr_i,
  output logic [NPINS-1:0] flag_o
);
  logic [NPINS-1:0] flag_q;

  // on clear, same-edge changes survive
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= '0;
    else if (clr_i) flag_q <= chg_i;
    else            flag_q <= flag_q | chg_i;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/pcint_mask.sv
module pcint_mask #(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic [NPINS-1:0] wdata_i,
  output logic [NPINS-1:0] mask_o
);
  logic [NPINS-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mask_q <= '0;
    else if (set_i)   mask_q <= mask_q | wdata_i;
    else if (clr_i)   mask_q <= mask_q & ~wdata_i;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/pcint_regif.sv
module pcint_regif
  import pcint_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NPINS-1:0]  mask_i,
  input  logic [NPINS-1:0]  flag_i,
  output pcint_dec_t        dec_o,
  output logic [NPINS-1:0]  rdata_o
);
  logic             wr, rd;
  logic [NPINS-1:0] rd_val;
  logic [NPINS-1:0] rdata_q;

  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;

  assign dec_o.mask_set = wr && (addr_i == OFF_MASK_SET);
  assign dec_o.mask_clr = wr && (addr_i == OFF_MASK_CLR);
  assign dec_o.mask_rd  = rd && (addr_i == OFF_MASK_RD);
  assign dec_o.stat_rd  = rd && (addr_i == OFF_STATUS);

  always_comb begin
    rd_val = '0;
    if (dec_o.mask_rd) rd_val = mask_i;
    if (dec_o.stat_rd) rd_val = flag_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rd_val;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/pcint_unit.sv
module pcint_unit
  import pcint_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NPINS-1:0]  pin_i,
  input  logic [NPINS-1:0]  pio_sel_i,
  input  logic [NPINS-1:0]  oe_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NPINS-1:0]  wdata_i,
  output logic [NPINS-1:0]  rdata_o,
  output logic              irq_o
);
  logic [NPINS-1:0] chg, smp, flag_q, mask_q;
  pcint_dec_t       dec;

  pcint_detect #(.NPINS(NPINS)) u_detect (
    .clk_i, .rst_ni, .pin_i, .pio_sel_i, .oe_i,
    .chg_o(chg), .smp_o(smp)
  );

  pcint_flags #(.NPINS(NPINS)) u_flags (
    .clk_i, .rst_ni, .chg_i(chg), .clr_i(dec.stat_rd), .flag_o(flag_q)
  );

  pcint_mask #(.NPINS(NPINS)) u_mask (
    .clk_i, .rst_ni, .set_i(dec.mask_set), .clr_i(dec.mask_clr),
    .wdata_i, .mask_o(mask_q)
  );

  pcint_regif #(.NPINS(NPINS)) u_regif (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i,
    .mask_i(mask_q), .flag_i(flag_q), .dec_o(dec), .rdata_o
  );

  assign irq_o = |(flag_q & mask_q);
endmodule

// File: rtl/pcint_unit_chk.sv
module pcint_unit_chk
  import pcint_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NPINS-1:0]  pin_i,
  input logic [NPINS-1:0]  pio_sel_i,
  input logic [NPINS-1:0]  oe_i,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [NPINS-1:0]  wdata_i,
  input logic [NPINS-1:0]  rdata_o,
  input logic [NPINS-1:0]  flag_q,
  input logic [NPINS-1:0]  mask_q,
  input logic [NPINS-1:0]  smp,
  input logic [NPINS-1:0]  chg
);
  logic stat_rd, mset, mclr;
  assign stat_rd = req_i && !we_i && (addr_i == OFF_STATUS);
  assign mset    = req_i && we_i && (addr_i == OFF_MASK_SET);
  assign mclr    = req_i && we_i && (addr_i == OFF_MASK_CLR);

  AST_NEW_FLAG_NEEDS_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flag_q & ~$past(flag_q)) & ~$past(pin_i ^ smp)) == '0); // R2

  AST_GATED_PIN_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flag_q & ~$past(flag_q)) & ~$past(pio_sel_i & ~oe_i)) == '0); // R3

  AST_STATUS_RETURNS_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd |=> rdata_o == $past(flag_q)); // R7

  AST_READ_KEEPS_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd |=> flag_q == $past(chg)); // R8

  AST_MASK_SET_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mset |=> (mask_q & $past(wdata_i)) == $past(wdata_i)); // R6

  AST_MASK_CLR_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mclr |=> (mask_q & $past(wdata_i)) == '0); // R6

  AST_MASK_KEEPS_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mset || mclr) |=> (flag_q & $past(flag_q)) == $past(flag_q)); // R9
endmodule

bind pcint_unit pcint_unit_chk #(.NPINS(NPINS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(pin_i), .pio_sel_i(pio_sel_i),
  .oe_i(oe_i), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .flag_q(flag_q), .mask_q(mask_q),
  .smp(smp), .chg(chg)
);

// File: tb/pcint_unit_test.sv
module pcint_unit_test;
  localparam int N = 32;
  localparam logic [7:0] A_SET = 8'h40, A_CLR = 8'h44, A_MRD = 8'h48, A_STAT = 8'h4C;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] pin = '0, sel = '1, oe = '0, wdata = '0;
  logic         req = 1'b0, we = 1'b0;
  logic [7:0]   addr = '0;
  logic [N-1:0] rdata;
  logic         irq;

  logic [N-1:0] m_flag = '0, m_mask = '0, m_smp = '0;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pcint_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .pio_sel_i(sel), .oe_i(oe),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input bit ok, input string tag, input logic [N-1:0] act,
                       input logic [N-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: drive, advance model, sample 1ns after the edge
  task automatic cyc(input logic r, input logic w, input logic [7:0] a,
                     input logic [N-1:0] wd, input string tag);
    logic [N-1:0] g, chg, exp_rd;
    req = r; we = w; addr = a; wdata = wd;
    g      = sel & ~oe;
    chg    = (pin ^ m_smp) & g;
    exp_rd = '0;
    if (r && !w && a == A_MRD) exp_rd = m_mask;
    if (r && !w && a == A_STAT) begin exp_rd = m_flag; m_flag = chg; end
    else m_flag = m_flag | chg;
    if (r && w && a == A_SET) m_mask = m_mask | wd;
    else if (r && w && a == A_CLR) m_mask = m_mask & ~wd;
    m_smp = (m_smp & ~g) | (pin & g);
    @(posedge clk); #1;
    req = 1'b0; we = 1'b0;
    check(irq == |(m_flag & m_mask), "R5 irq", {31'd0, irq}, {31'd0, |(m_flag & m_mask)});
    if (r && !w) check(rdata == exp_rd, tag, rdata, exp_rd);
  endtask

  task automatic idle();
    cyc(1'b0, 1'b0, 8'h00, '0, "idle");
  endtask

  task automatic rd_stat(input string tag);
    cyc(1'b1, 1'b0, A_STAT, '0, tag);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    check(irq == 1'b0, "R1 irq in reset", {31'd0, irq}, '0);
    check(rdata == '0, "R1 rdata in reset", rdata, '0);
    rst_n = 1'b1;
    cyc(1'b1, 1'b0, A_MRD, '0, "R1 mask after reset");
    rd_stat("R1 flags after reset");

    // R6: mask set, clear, readback
    cyc(1'b1, 1'b1, A_SET, 32'hF0F0_1234, "R6 set");
    cyc(1'b1, 1'b0, A_MRD, '0, "R6 readback after set");
    cyc(1'b1, 1'b1, A_CLR, 32'h3030_0204, "R6 clr");
    cyc(1'b1, 1'b0, A_MRD, '0, "R6 readback after clr");
    cyc(1'b1, 1'b1, A_SET, '1, "R6 set all");

    // R2 R3 R4 R11: every pin x select/oe combination
    for (int i = 0; i < N; i++) begin
      for (int c = 0; c < 4; c++) begin
        sel = '1; oe = '0;
        sel[i] = c[0]; oe[i] = c[1];
        pin[i] = ~pin[i];
        idle();
        rd_stat((c == 1) ? "R2 watched pin change" :
                (c[1] ? "R3 oe pin ignored" : "R4 peripheral pin ignored"));
        sel = '1; oe = '0;
        idle();
        rd_stat("R11 change on return to watch");
        idle();
        rd_stat("R2 steady pin no flag");
      end
    end

    // arithmetic multi-pin patterns, interleaved mask and reads
    for (int i = 0; i < 300; i++) begin
      pin = pin ^ (32'h9E37_79B9 * (i + 1));
      sel = ~(32'h0101_0101 << (i % 8));
      oe  = 32'h0000_8001 << (i % 16);
      case (i % 5)
        0: rd_stat("R7 pattern status read");
        1: cyc(1'b1, 1'b1, A_CLR, 32'h1234_5678 * i, "R9 mask clr");
        2: cyc(1'b1, 1'b1, A_SET, 32'h8765_4321 * i, "R9 mask set");
        3: cyc(1'b1, 1'b0, A_MRD, '0, "R6 pattern mask read");
        default: idle();
      endcase
    end

    // R8: change at same edge as status read
    sel = '1; oe = '0;
    idle();
    rd_stat("R7 clear before R8");
    pin[5] = ~pin[5];
    rd_stat("R8 read excludes same-edge change");
    rd_stat("R8 same-edge change kept");

    // R9: mask off and on over pending flag
    pin[9] = ~pin[9];
    idle();
    cyc(1'b1, 1'b1, A_CLR, 32'h0000_0200, "R9 mask off");
    check(irq == 1'b0, "R9 irq low masked", {31'd0, irq}, '0);
    cyc(1'b1, 1'b1, A_SET, 32'h0000_0200, "R9 mask on");
    check(irq == 1'b1, "R9 irq back", {31'd0, irq}, 32'd1);

    // R10: writes to read-only/unmapped addresses, unmapped reads
    cyc(1'b1, 1'b1, A_STAT, '1, "R10 write status");
    cyc(1'b1, 1'b1, A_MRD, '0, "R10 write mask read addr");
    cyc(1'b1, 1'b1, 8'h10, '0, "R10 write unmapped");
    cyc(1'b1, 1'b0, A_MRD, '0, "R10 mask unchanged");
    for (int a = 0; a < 256; a += 4)
      if (a != A_MRD && a != A_STAT) cyc(1'b1, 1'b0, a[7:0], '0, "R10 unmapped read zero");
    rd_stat("R10 flags unchanged");
    rd_stat("R7 flags cleared");

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule